// File: doc/BRIEF.md
# Vector Instruction Legality Checker

This block decides, at decode time, whether a vector instruction must raise an illegal-instruction exception. It takes the raw 32-bit instruction word, a handful of class bits already produced by the main decoder, the current vector type configuration (the illegal-configuration bit, the element-width code and the group-multiplier code) and the current start-element index. It evaluates eight independent legality categories and registers them, together with their OR, one clock after the instruction is presented.

The categories cover a reserved configuration or width encoding, an illegal configuration bit, an illegal effective element width, an illegal effective group multiplier, register numbers that do not sit on a group boundary, a masked write to the mask register, a forbidden overlap of source and destination groups, and a nonzero start index. Configuration-setting instructions are exempt from every category. Faults that can only be seen during memory access are outside this block.

Encodings used throughout: element-width code `s` means SEW = 8·2^s (codes 4–7 reserved). Group-multiplier code gives log2(LMUL): 000→0, 001→1, 010→2, 011→3, 111→−1, 110→−2, 101→−3, 100 reserved. Register fields: vd = instr[11:7], vs1 = instr[19:15], vs2 = instr[24:20], funct3/width = instr[14:12]. Memory width codes 000, 101, 110, 111 mean EEW 8, 16, 32, 64.

Top module: `vec_legal_chk`

## Requirements
- R1: Outputs are registered: `out_valid` follows `in_valid` one cycle later, `out_cat` holds the eight category flags of the instruction presented in the previous cycle (all zero when it was not valid, and after reset), and `out_illegal` is the OR of those flags. Category bit order: 0 reserved, 1 config-illegal, 2 element width, 3 group multiplier, 4 alignment, 5 mask overlap, 6 group overlap, 7 start index.
- R2: An instruction with `cls_cfg` set raises no category, whatever the configuration, start index or register fields.
- R3: Bit 1 is set for any non-config instruction while `vt_vill` is 1.
- R4: Bit 7 is set when `vstart` is nonzero for any instruction that is neither config nor load/store.
- R5: Bit 0 is set for a non-config instruction when the group-multiplier code is 100 or the element-width code is 4 or above, and for a load/store whose width code is 001–100.
- R6: Bit 2 is set when a floating-point instruction has SEW 8, a widening or narrowing instruction has SEW 64, or an extension with log2 factor f (`cls_ext_log`, 0 = not an extension) has s < f.
- R7: Bit 3 is set when: a widening or narrowing instruction has log2(LMUL) = 3; an extension has log2(LMUL) − f below −3; a load/store has log2(EEW/8) − s + log2(LMUL) outside −3..3; a 16-bit-index gather has 1 − s + log2(LMUL) outside −3..3.
- R8: Bit 4 is set when a checked register is not a multiple of its group size 2^max(0,min(3,g)), where g is log2(LMUL) except: vd of widening uses +1, vs2 of narrowing uses +1, vs2 of an extension uses −f, vs1 of a 16-bit-index gather uses its index EMUL, vd of a load/store uses its data EMUL, and vd of a mask-destination instruction uses 0. vd is always checked; vs2 for all but loads/stores; vs1 only for non-load/store, non-extension instructions with funct3 000, 001 or 010.
- R9: Bit 5 is set for a masked (`cls_masked`) non-config instruction with vd = 0 unless it writes a mask destination.
- R10: Bit 6 is set for widening, narrowing, extension or 16-bit-index gather instructions (not loads/stores) when the vd group overlaps the vs2 group, or the vs1 group when vs1 is checked under R8.
- R11: Bits 2, 3, 4 and 6 are forced to zero when R5 reports a reserved encoding for the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction presented this cycle |
| instr | input | 32 | Raw instruction word |
| cls_cfg | input | 1 | Configuration-setting instruction |
| cls_ldst | input | 1 | Vector load or store |
| cls_wide | input | 1 | Widening operation |
| cls_narrow | input | 1 | Narrowing operation |
| cls_ext_log | input | 2 | log2 of extension factor, 0 when not an extension |
| cls_fp | input | 1 | Floating-point operation |
| cls_masked | input | 1 | Reads v0 as a mask |
| cls_mask_dst | input | 1 | Destination is a mask register |
| cls_gat16 | input | 1 | Gather with 16-bit indices |
| vt_vill | input | 1 | Illegal-configuration bit of the vector type |
| vt_sew | input | 3 | Element-width code |
| vt_lmul | input | 3 | Group-multiplier code |
| vstart | input | VSTART_W | Start-element index |
| out_valid | output | 1 | Result valid |
| out_illegal | output | 1 | OR of all categories |
| out_cat | output | 8 | Per-category flags |

## Verification
Several categories commonly fire in the same cycle: a masked write to v0 can coincide with a nonzero start index, an illegal configuration bit and a misaligned vs2, and a widening group that overflows the register file raises both the multiplier and the overlap categories. The bench provokes these with directed vectors that set several faults at once, then with a long random stream biased towards such collisions. Each category bit is compared on its own against a behavioural reference every cycle, so one category masking another in the OR would be reported.

// File: rtl/vlc_pkg.sv
// Shared constants and helpers for the vector legality checker.
// Assumes register groups never exceed eight registers.
package vlc_pkg;
    localparam int NUM_CAT    = 8;
    localparam int CAT_RSV    = 0;
    localparam int CAT_VILL   = 1;
    localparam int CAT_EEW    = 2;
    localparam int CAT_EMUL   = 3;
    localparam int CAT_ALIGN  = 4;
    localparam int CAT_V0     = 5;
    localparam int CAT_OVLP   = 6;
    localparam int CAT_VSTART = 7;

    // Signed log2 of a group multiplier; covers -8..7.
    typedef logic signed [3:0] glog_t;

    // Decode the group-multiplier code into log2(LMUL); reserved code maps to 0.
    function automatic glog_t lmul_to_log(input logic [2:0] code);
        case (code)
            3'd1:    return 4'sd1;
            3'd2:    return 4'sd2;
            3'd3:    return 4'sd3;
            3'd5:    return -4'sd3;
            3'd6:    return -4'sd2;
            3'd7:    return -4'sd1;
            default: return 4'sd0;
        endcase
    endfunction

    // Low-bit mask that a register number must clear for a group of 2^g.
    function automatic logic [2:0] grp_mask(input glog_t g);
        if (g <= 4'sd0)      return 3'd0;
        else if (g == 4'sd1) return 3'd1;
        else if (g == 4'sd2) return 3'd3;
        else                 return 3'd7;
    endfunction

    // True when a log2 multiplier lies outside 1/8..8.
    function automatic logic log_out_of_range(input glog_t g);
        return (g < -4'sd3) || (g > 4'sd3);
    endfunction
endpackage

// File: rtl/vlc_width_calc.sv
// Width calculator: decodes the vector type and the memory width code,
// derives effective element width / group multiplier faults, and the
// group log2 used for each register operand. Purely combinational.
// Assumes class bits are mutually consistent as produced by the decoder.
module vlc_width_calc
    import vlc_pkg::*;
(
    input  logic [2:0] vsew,
    input  logic [2:0] vlmul,
    input  logic [2:0] width_code,
    input  logic       is_ldst,
    input  logic       is_wide,
    input  logic       is_narrow,
    input  logic [1:0] ext_log,
    input  logic       is_fp,
    input  logic       is_mask_dst,
    input  logic       is_gat16,
    output logic       vt_rsv,
    output logic       w_rsv,
    output logic       eew_bad,
    output logic       emul_bad,
    output glog_t      vd_log,
    output glog_t      vs1_log,
    output glog_t      vs2_log
);
    glog_t s_log, l_log, f_log, e_log, ld_emul, gi_emul;
    logic  is_ext, wn;

    // Decode type fields and width code into signed logs.
    always_comb begin
        s_log = glog_t'({2'b00, vsew[1:0]});
        l_log = lmul_to_log(vlmul);
        f_log = glog_t'({2'b00, ext_log});
        case (width_code)
            3'b101:  e_log = 4'sd1;
            3'b110:  e_log = 4'sd2;
            3'b111:  e_log = 4'sd3;
            default: e_log = 4'sd0;
        endcase
        ld_emul = e_log - s_log + l_log;
        gi_emul = 4'sd1 - s_log + l_log;
        is_ext  = (ext_log != 2'd0);
        wn      = is_wide | is_narrow;
    end

    // Reserved encodings of the type and of the memory width.
    always_comb begin
        vt_rsv = vsew[2] | (vlmul == 3'b100);
        w_rsv  = is_ldst && (width_code != 3'b000) && (width_code[2:1] != 2'b11)
                 && (width_code != 3'b101);
    end

    // Effective element width and group multiplier faults.
    always_comb begin
        eew_bad  = (is_fp && vsew[1:0] == 2'd0)
                 | (wn && vsew[1:0] == 2'd3)
                 | (is_ext && (s_log < f_log));
        emul_bad = (is_ldst && log_out_of_range(ld_emul))
                 | (wn && (l_log == 4'sd3))
                 | (is_ext && ((l_log - f_log) < -4'sd3))
                 | (is_gat16 && log_out_of_range(gi_emul));
    end

    // Group size (log2) for each register operand.
    always_comb begin
        if (is_mask_dst)   vd_log = 4'sd0;
        else if (is_ldst)  vd_log = ld_emul;
        else if (is_wide)  vd_log = l_log + 4'sd1;
        else               vd_log = l_log;
        if (is_narrow)     vs2_log = l_log + 4'sd1;
        else if (is_ext)   vs2_log = l_log - f_log;
        else               vs2_log = l_log;
        vs1_log = is_gat16 ? gi_emul : l_log;
    end
endmodule

// File: rtl/vlc_reg_check.sv
// Register checker: tests each enabled operand for alignment to its group
// and tests the destination group against the source groups for overlap.
// Assumes groups of at most eight registers; purely combinational.
module vlc_reg_check
    import vlc_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] vd,
    input  logic [REG_W-1:0] vs1,
    input  logic [REG_W-1:0] vs2,
    input  glog_t            vd_log,
    input  glog_t            vs1_log,
    input  glog_t            vs2_log,
    input  logic             use_vs1,
    input  logic             use_vs2,
    input  logic             ovlp_en,
    output logic             align_bad,
    output logic             ovlp_bad
);
    localparam int NUM_OP = 3;
    localparam int SUM_W  = REG_W + 1;

    logic [REG_W-1:0] op_reg [NUM_OP];
    glog_t            op_log [NUM_OP];
    logic [NUM_OP-1:0] op_en, op_mis;
    logic [3:0]       len_vd, len_vs1, len_vs2;
    logic             hit1, hit2;

    // True when [a, a+la) and [b, b+lb) share a register.
    function automatic logic spans_meet(input logic [REG_W-1:0] a, input logic [3:0] la,
                                        input logic [REG_W-1:0] b, input logic [3:0] lb);
        logic [SUM_W-1:0] a_end, b_end;
        a_end = {1'b0, a} + SUM_W'(la);
        b_end = {1'b0, b} + SUM_W'(lb);
        return ({1'b0, a} < b_end) && ({1'b0, b} < a_end);
    endfunction

    // Collect operands in a fixed order: vd, vs1, vs2.
    always_comb begin
        op_reg[0] = vd;  op_log[0] = vd_log;  op_en[0] = 1'b1;
        op_reg[1] = vs1; op_log[1] = vs1_log; op_en[1] = use_vs1;
        op_reg[2] = vs2; op_log[2] = vs2_log; op_en[2] = use_vs2;
    end

    // One alignment test per operand.
    for (genvar i = 0; i < NUM_OP; i++) begin : g_align
        assign op_mis[i] = op_en[i]
                         && ((op_reg[i] & REG_W'(grp_mask(op_log[i]))) != '0);
    end
    assign align_bad = |op_mis;

    // Destination group against each vector source group.
    always_comb begin
        len_vd   = {1'b0, grp_mask(vd_log)}  + 4'd1;
        len_vs1  = {1'b0, grp_mask(vs1_log)} + 4'd1;
        len_vs2  = {1'b0, grp_mask(vs2_log)} + 4'd1;
        hit2     = spans_meet(vd, len_vd, vs2, len_vs2);
        hit1     = use_vs1 && spans_meet(vd, len_vd, vs1, len_vs1);
        ovlp_bad = ovlp_en && (hit1 || hit2);
    end
endmodule

// File: rtl/vec_legal_chk.sv
// Vector legality checker top: combines the width calculator and register
// checker with the configuration, start-index and mask checks, and
// registers the eight category flags and their OR one cycle later.
// Assumes class bits come from the main decoder in the same cycle.
module vec_legal_chk
    import vlc_pkg::*;
#(
    parameter int VSTART_W = 8,
    parameter int NUM_VREG = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [31:0]         instr,
    input  logic                cls_cfg,
    input  logic                cls_ldst,
    input  logic                cls_wide,
    input  logic                cls_narrow,
    input  logic [1:0]          cls_ext_log,
    input  logic                cls_fp,
    input  logic                cls_masked,
    input  logic                cls_mask_dst,
    input  logic                cls_gat16,
    input  logic                vt_vill,
    input  logic [2:0]          vt_sew,
    input  logic [2:0]          vt_lmul,
    input  logic [VSTART_W-1:0] vstart,
    output logic                out_valid,
    output logic                out_illegal,
    output logic [7:0]          out_cat
);
    localparam int REG_W = $clog2(NUM_VREG);

    logic [REG_W-1:0]   f_vd, f_vs1, f_vs2;
    logic [2:0]         f_f3;
    logic               vt_rsv, w_rsv, eew_bad, emul_bad, align_bad, ovlp_bad;
    logic               dep_ok, is_ext, use_vs1, use_vs2, ovlp_en;
    glog_t              vd_log, vs1_log, vs2_log;
    logic [NUM_CAT-1:0] cat_nxt;
    logic               unused_bits;

    assign f_vd        = instr[7 +: REG_W];
    assign f_vs1       = instr[15 +: REG_W];
    assign f_vs2       = instr[20 +: REG_W];
    assign f_f3        = instr[14:12];
    assign unused_bits = ^{instr[31:25], instr[6:0]};

    vlc_width_calc u_width (
        .vsew        (vt_sew),
        .vlmul       (vt_lmul),
        .width_code  (f_f3),
        .is_ldst     (cls_ldst),
        .is_wide     (cls_wide),
        .is_narrow   (cls_narrow),
        .ext_log     (cls_ext_log),
        .is_fp       (cls_fp),
        .is_mask_dst (cls_mask_dst),
        .is_gat16    (cls_gat16),
        .vt_rsv      (vt_rsv),
        .w_rsv       (w_rsv),
        .eew_bad     (eew_bad),
        .emul_bad    (emul_bad),
        .vd_log      (vd_log),
        .vs1_log     (vs1_log),
        .vs2_log     (vs2_log)
    );

    // Which operands are vector registers and whether overlap applies.
    always_comb begin
        is_ext  = (cls_ext_log != 2'd0);
        use_vs2 = !cls_ldst;
        use_vs1 = !cls_ldst && !is_ext && (f_f3 <= 3'd2);
        ovlp_en = !cls_ldst && (cls_wide || cls_narrow || is_ext || cls_gat16);
        dep_ok  = !cls_cfg && !vt_rsv && !w_rsv;
    end

    vlc_reg_check #(.REG_W(REG_W)) u_regs (
        .vd        (f_vd),
        .vs1       (f_vs1),
        .vs2       (f_vs2),
        .vd_log    (vd_log),
        .vs1_log   (vs1_log),
        .vs2_log   (vs2_log),
        .use_vs1   (use_vs1),
        .use_vs2   (use_vs2),
        .ovlp_en   (ovlp_en),
        .align_bad (align_bad),
        .ovlp_bad  (ovlp_bad)
    );

    // Assemble the eight category flags with their exemptions.
    always_comb begin
        cat_nxt             = '0;
        cat_nxt[CAT_RSV]    = !cls_cfg && (vt_rsv || w_rsv);
        cat_nxt[CAT_VILL]   = !cls_cfg && vt_vill;
        cat_nxt[CAT_EEW]    = dep_ok && eew_bad;
        cat_nxt[CAT_EMUL]   = dep_ok && emul_bad;
        cat_nxt[CAT_ALIGN]  = dep_ok && align_bad;
        cat_nxt[CAT_V0]     = !cls_cfg && cls_masked && !cls_mask_dst && (f_vd == '0);
        cat_nxt[CAT_OVLP]   = dep_ok && ovlp_bad;
        cat_nxt[CAT_VSTART] = !cls_cfg && !cls_ldst && (vstart != '0);
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_cat     <= '0;
        end else begin
            out_valid   <= in_valid;
            out_illegal <= in_valid && (|cat_nxt);
            out_cat     <= in_valid ? cat_nxt : '0;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_illegal && out_cat == '0)); // R1
    AST_CFG_EXEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls_cfg) |=> !out_illegal); // R2
    AST_VILL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cls_cfg && vt_vill) |=> (out_cat[1] && out_illegal)); // R3
    AST_VSTART_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cls_cfg && !cls_ldst && vstart != '0) |=> out_cat[7]); // R4
    AST_RSV_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cls_cfg && vt_lmul == 3'b100) |=> (out_cat[0] && out_cat[3:2] == 2'b00)); // R11
    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cls_cfg && cls_masked && !cls_mask_dst && instr[11:7] == 5'd0)
        |=> out_cat[5]); // R9
endmodule

// File: tb/test_vec_legal_chk.sv
// Bench for vec_legal_chk: directed vectors then a random stream, every
// category compared each cycle against a behavioural reference model.
module test_vec_legal_chk;
    localparam int VSTART_W = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [31:0]         instr = '0;
    logic                cls_cfg = 0, cls_ldst = 0, cls_wide = 0, cls_narrow = 0;
    logic [1:0]          cls_ext_log = 0;
    logic                cls_fp = 0, cls_masked = 0, cls_mask_dst = 0, cls_gat16 = 0;
    logic                vt_vill = 0;
    logic [2:0]          vt_sew = 0, vt_lmul = 0;
    logic [VSTART_W-1:0] vstart = '0;
    logic                out_valid, out_illegal;
    logic [7:0]          out_cat;

    int checks = 0;
    int failures = 0;
    string cat_req [8] = '{"R5", "R3", "R6", "R7", "R8", "R9", "R10", "R4"};

    always #2 clk = ~clk;

    vec_legal_chk #(.VSTART_W(VSTART_W)) i_vec_legal_chk (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .cls_cfg(cls_cfg), .cls_ldst(cls_ldst), .cls_wide(cls_wide),
        .cls_narrow(cls_narrow), .cls_ext_log(cls_ext_log), .cls_fp(cls_fp),
        .cls_masked(cls_masked), .cls_mask_dst(cls_mask_dst), .cls_gat16(cls_gat16),
        .vt_vill(vt_vill), .vt_sew(vt_sew), .vt_lmul(vt_lmul), .vstart(vstart),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_cat(out_cat)
    );

    function automatic int glen(input int g);
        if (g <= 0) return 1;
        if (g >= 3) return 8;
        return 1 << g;
    endfunction

    function automatic bit meet(input int a, input int la, input int b, input int lb);
        return (a < b + lb) && (b < a + la);
    endfunction

    // Behavioural reference built from the requirement text.
    function automatic logic [7:0] ref_cats();
        logic [7:0] c = '0;
        int s = int'(vt_sew), l, f = int'(cls_ext_log), w = int'(instr[14:12]);
        int e, ld, gi, dl, l1, l2, vd, v1, v2;
        bit vtr, wr, dep, u1, ov;
        case (vt_lmul)
            3'd1: l = 1;  3'd2: l = 2;  3'd3: l = 3;
            3'd5: l = -3; 3'd6: l = -2; 3'd7: l = -1;
            default: l = 0;
        endcase
        vd = int'(instr[11:7]); v1 = int'(instr[19:15]); v2 = int'(instr[24:20]);
        vtr = (s >= 4) || (vt_lmul == 3'b100);
        wr  = cls_ldst && !(w == 0 || w >= 5);
        e   = (w >= 5) ? w - 4 : 0;
        dep = !cls_cfg && !vtr && !wr;
        ld  = e - s + l;
        gi  = 1 - s + l;
        c[0] = !cls_cfg && (vtr || wr);
        c[1] = !cls_cfg && vt_vill;
        c[2] = dep && ((cls_fp && s == 0) || ((cls_wide || cls_narrow) && s == 3) ||
                       (f != 0 && s < f));
        c[3] = dep && ((cls_ldst && (ld < -3 || ld > 3)) ||
                       ((cls_wide || cls_narrow) && l + 1 > 3) ||
                       (f != 0 && l - f < -3) ||
                       (cls_gat16 && (gi < -3 || gi > 3)));
        dl = cls_mask_dst ? 0 : cls_ldst ? ld : cls_wide ? l + 1 : l;
        l2 = cls_narrow ? l + 1 : (f != 0) ? l - f : l;
        l1 = cls_gat16 ? gi : l;
        u1 = !cls_ldst && f == 0 && w <= 2;
        c[4] = dep && ((vd % glen(dl) != 0) || (!cls_ldst && v2 % glen(l2) != 0) ||
                       (u1 && v1 % glen(l1) != 0));
        c[5] = !cls_cfg && cls_masked && !cls_mask_dst && vd == 0;
        ov = !cls_ldst && (cls_wide || cls_narrow || f != 0 || cls_gat16);
        c[6] = dep && ov && (meet(vd, glen(dl), v2, glen(l2)) ||
                             (u1 && meet(vd, glen(dl), v1, glen(l1))));
        c[7] = !cls_cfg && !cls_ldst && vstart != 0;
        return c;
    endfunction

    function automatic logic [31:0] mk(input int vd, input int vs1, input int vs2, input int f3);
        return {6'b0, 1'b1, 5'(vs2), 5'(vs1), 3'(f3), 5'(vd), 7'b1010111};
    endfunction

    task automatic chk(input bit ok, input string req, input string note,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s (%s): actual=%0d expected=%0d", req, note, act, exp);
        end
    endtask

    // Apply the inputs currently set, wait for the registered result, compare.
    task automatic run_vec(input string note);
        logic [7:0] ec = in_valid ? ref_cats() : 8'h00;
        logic       ev = in_valid;
        @(negedge clk);
        chk(out_valid == ev, "R1", {note, " valid"}, out_valid, ev);
        chk(out_illegal == (|ec), "R1", {note, " illegal"}, out_illegal, |ec);
        for (int k = 0; k < 8; k++)
            chk(out_cat[k] == ec[k], cat_req[k], note, out_cat[k], ec[k]);
    endtask

    task automatic set_cls(input bit cfg, input bit ldst, input bit wide, input bit nar,
                           input int ext, input bit fp, input bit msk, input bit mdst,
                           input bit g16);
        cls_cfg = cfg; cls_ldst = ldst; cls_wide = wide; cls_narrow = nar;
        cls_ext_log = 2'(ext); cls_fp = fp; cls_masked = msk; cls_mask_dst = mdst;
        cls_gat16 = g16;
    endtask

    task automatic set_vt(input bit vill, input int sew, input int lmul, input int vst);
        vt_vill = vill; vt_sew = 3'(sew); vt_lmul = 3'(lmul); vstart = VSTART_W'(vst);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 0 && out_illegal == 0 && out_cat == 0, "R1", "reset",
            int'(out_cat), 0);
        rst_n = 1'b1;
        // R1: invalid input with faults present stays quiet
        in_valid = 0; instr = mk(0, 0, 0, 0); set_cls(0,0,0,0,0,0,1,0,0); set_vt(1,0,0,3);
        run_vec("R1 idle");
        in_valid = 1;
        // R2: config exempt from everything
        set_cls(1,0,0,0,0,0,1,0,0); set_vt(1,5,4,7); instr = mk(0, 3, 1, 7);
        run_vec("R2 config");
        // R3: vill on plain op
        set_cls(0,0,0,0,0,0,0,0,0); set_vt(1,1,0,0); instr = mk(2, 3, 4, 0);
        run_vec("R3 vill");
        // R4: start index on plain op, then exempt load/store
        set_vt(0,1,0,5); run_vec("R4 vstart");
        set_cls(0,1,0,0,0,0,0,0,0); instr = mk(4, 0, 0, 0); run_vec("R4 ldst exempt");
        // R5: reserved multiplier, reserved width, reserved memory width
        set_cls(0,0,0,0,0,1,0,0,0); set_vt(0,0,4,0); instr = mk(1, 1, 1, 1);
        run_vec("R5 R11 lmul rsv");
        set_vt(0,5,0,0); run_vec("R5 R11 sew rsv");
        set_cls(0,1,0,0,0,0,0,0,0); set_vt(0,0,0,0); instr = mk(2, 0, 0, 2);
        run_vec("R5 mem width rsv");
        // R6: fp sew 8, widening sew 64, extension factor 8 at sew 32
        set_cls(0,0,0,0,0,1,0,0,0); set_vt(0,0,0,0); instr = mk(2, 4, 6, 1);
        run_vec("R6 fp sew8");
        set_cls(0,0,1,0,0,0,0,0,0); set_vt(0,3,0,0); instr = mk(2, 8, 9, 0);
        run_vec("R6 wide sew64");
        set_cls(0,0,0,0,3,0,0,0,0); set_vt(0,2,0,0); instr = mk(2, 3, 9, 2);
        run_vec("R6 ext f8");
        // R7: widening at LMUL 8, ld emul 16, gather16 at LMUL 8 sew 8, ext vf8 at 1/2
        set_cls(0,0,1,0,0,0,0,0,0); set_vt(0,0,3,0); instr = mk(16, 0, 8, 0);
        run_vec("R7 wide lmul8");
        set_cls(0,1,0,0,0,0,0,0,0); set_vt(0,0,1,0); instr = mk(8, 0, 0, 7);
        run_vec("R7 ld emul");
        set_cls(0,0,0,0,0,0,0,0,1); set_vt(0,0,3,0); instr = mk(8, 16, 24, 0);
        run_vec("R7 gather16");
        set_cls(0,0,0,0,3,0,0,0,0); set_vt(0,3,7,0); instr = mk(3, 0, 5, 2);
        run_vec("R7 ext frac");
        // R8: misaligned vd at LMUL 4, scalar vs1 not checked, fractional free
        set_cls(0,0,0,0,0,0,0,0,0); set_vt(0,1,2,0); instr = mk(2, 4, 8, 0);
        run_vec("R8 vd misaligned");
        set_vt(0,1,1,0); instr = mk(2, 3, 4, 4); run_vec("R8 scalar vs1");
        set_vt(0,1,6,0); instr = mk(3, 5, 7, 0); run_vec("R8 fractional");
        // R9: masked write to v0, and mask destination allowed
        set_cls(0,0,0,0,0,0,1,0,0); set_vt(0,0,0,0); instr = mk(0, 1, 2, 0);
        run_vec("R9 masked v0");
        set_cls(0,0,0,0,0,0,1,1,0); run_vec("R9 mask dst");
        // R10: widening dst over source, narrowing dst over wide source
        set_cls(0,0,1,0,0,0,0,0,0); set_vt(0,0,0,0); instr = mk(2, 6, 3, 0);
        run_vec("R10 wide overlap");
        set_cls(0,0,0,1,0,0,0,0,0); instr = mk(5, 8, 4, 4); run_vec("R10 narrow overlap");
        // Collisions: vill + vstart + masked v0 + misaligned vs2 in one cycle
        set_cls(0,0,0,0,0,0,1,0,0); set_vt(1,2,1,9); instr = mk(0, 2, 3, 0);
        run_vec("R3 R4 R8 R9 together");
        // Random stream biased towards collisions
        for (int n = 0; n < 3000; n++) begin
            int kind = $urandom_range(0, 6);
            in_valid = ($urandom_range(0, 15) != 0);
            instr = $urandom();
            if ($urandom_range(0, 1) == 1) instr[24:20] = 5'($urandom_range(0, 3) * 2);
            set_cls(kind == 1, kind == 2, kind == 3, kind == 4,
                    (kind == 5) ? $urandom_range(1, 3) : 0,
                    (kind <= 4 && kind != 1 && kind != 2) ? $urandom_range(0, 1) : 0,
                    $urandom_range(0, 2) == 0, kind == 0 && $urandom_range(0, 3) == 0,
                    kind == 6);
            set_vt($urandom_range(0, 7) == 0,
                   ($urandom_range(0, 7) == 0) ? $urandom_range(4, 7) : $urandom_range(0, 3),
                   $urandom_range(0, 7),
                   ($urandom_range(0, 5) == 0) ? $urandom_range(1, 255) : 0);
            run_vec("random R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule